// File: doc/BRIEF.md
# Byte-Wide SPI Master Controller

This block is an 8-bit SPI master that a host CPU drives through a small byte-wide register bus. The host sets the clock polarity, the clock phase and the bit order in a control register, and picks the serial clock rate in a rate register. It then writes a byte to the data address. That write starts an 8-bit full-duplex exchange on SCLK, MOSI and MISO. When the exchange ends, the host reads the received byte from the same address. Slave select is not generated by the shift engine. It comes from bit 3 of a general-purpose port register, and it only reaches the pin when bit 3 of the matching direction register is set.

Three sticky status flags report the outcome: transfer done, write collision and mode fault. A flag clears only when the host reads the status register and then reads the data register. Two interrupt lines, one for done and one for mode fault, follow their flags. Both lines are gated by the interrupt-enable bit. In master mode with the select-output bit clear, a low level on the external select input is treated as another master taking the bus. The block then sets the fault flag, drops its master bit and abandons the byte in flight.

The shift engine is a four-state machine:
- IDLE: waits for a start.
- LEAD: half a serial period that ends in the leading SCLK edge.
- TRAIL: half a serial period that ends in the trailing SCLK edge.
- FINISH: a single cycle that raises the done flag.

Its transitions are:
- IDLE to LEAD on an accepted data write.
- LEAD to TRAIL on a rate tick.
- TRAIL to LEAD on a rate tick while bits remain.
- TRAIL to FINISH on the tick of the eighth bit.
- FINISH to IDLE unconditionally.
- Any state to IDLE on a mode-fault abort.

Top module: `spi_host_ctrl`

## Requirements
- R1: Registers sit at these offsets: control 0x00, auxiliary control 0x01, rate 0x04, status 0x05, data 0x09, port 0x0D, direction 0x10. All of them reset to 0x00.
  - Control bits: 7 interrupt enable, 6 block enable, 4 master, 3 clock polarity, 2 clock phase, 1 select-output enable, 0 LSB first. Bit 5 reads 0.
  - The auxiliary, port and direction registers read back exactly what was written.
  - Unmapped offsets read 0x00.
- R2: A data write is accepted when the block is enabled, in master mode and idle. It starts one 8-bit exchange. After the exchange, a read of the data address returns the byte shifted in on MISO.
- R3: The rate register holds a 3-bit prescale P in bits 6:4 and a 3-bit exponent E in bits 2:0. Bits 7 and 3 read 0. Each SCLK half period lasts H = (P+1)·2^E bus clocks. The done flag is not yet set 16·H clocks after the edge that accepts the data write, and is set one clock later.
- R4: SCLK rests at the clock-polarity level whenever no byte is shifting.
  - With phase 0, MOSI holds a bit from before the leading edge until the trailing edge, and MISO is sampled on the leading edge.
  - With phase 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: With LSB first clear, bit 7 is shifted first on both MOSI and MISO. With it set, bit 0 is shifted first.
- R6: Status bit 7 is the done flag.
  - The done interrupt equals the done flag ANDed with the interrupt-enable bit.
  - The fault interrupt equals the fault flag (status bit 4) ANDed with the interrupt-enable bit.
- R7: A data write while a byte is shifting is rejected. It sets status bit 6, and neither the byte on MOSI nor the received byte changes.
- R8: A flag clears only on a data read that follows a status read in which that flag was already set. A data read without a status read before it leaves the flags set.
- R9: A mode fault occurs when the block is enabled, in master mode, with select-output enable clear, and the select input is low. On a mode fault:
  - status bit 4 sets;
  - the control master bit clears;
  - the byte in flight is abandoned: SCLK returns to its rest level and no done flag follows.
- R10: The slave-select pin equals bit 3 of the port register when bit 3 of the direction register is 1, and is high otherwise.
- R11: A data write while the enable bit is 0 starts nothing. SCLK stays at rest, and the status stays 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; read side effects take place at the end of the cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, valid in the same cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Slave select, active low, driven from the port register |
| ss_in_n | input | 1 | External select sense used for mode-fault detection |
| irq_done | output | 1 | Transfer-complete interrupt |
| irq_fault | output | 1 | Mode-fault interrupt |

## Verification
The done flag is due exactly 16·H + 1 clocks after the edge that accepts the data write, with H the half period set by the rate register. The bench counts 16·H falling edges after the write and expects the interrupt low at that point. It then expects the interrupt high one falling edge later, under several prescale and exponent settings. Register reads and the select pin are combinational, so they are sampled shortly after the falling edge of the cycle that addresses them. Read side effects, such as flag clearing, are judged one cycle later. The slave model shifts on SCLK edges, so the bytes it reports are compared only after its sixteenth edge. The collision and fault cases wait for the interrupt line rather than count cycles.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int FRAME_BITS = 8;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    // register offsets (software decodes these)
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_AUX  = 'h01;
    localparam int OFS_RATE = 'h04;
    localparam int OFS_STAT = 'h05;
    localparam int OFS_DATA = 'h09;
    localparam int OFS_PORT = 'h0D;
    localparam int OFS_DIR  = 'h10;

    // rate register layout
    localparam int RATE_PRE_LSB = 4;
    localparam int RATE_PRE_W   = 3;
    localparam int RATE_EXP_W   = 3;

    // status bit positions
    localparam int STAT_DONE_BIT  = 7;
    localparam int STAT_COLL_BIT  = 6;
    localparam int STAT_FAULT_BIT = 4;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LEAD,
        ENG_TRAIL,
        ENG_FINISH
    } eng_state_t;

    typedef struct packed {
        logic irq_en;
        logic enable;
        logic master;
        logic cpol;
        logic cpha;
        logic ss_drive;
        logic lsb_first;
    } ctl_t;

    function automatic ctl_t ctl_from_byte(input logic [7:0] b);
        ctl_t c;
        c.irq_en    = b[7];
        c.enable    = b[6];
        c.master    = b[4];
        c.cpol      = b[3];
        c.cpha      = b[2];
        c.ss_drive  = b[1];
        c.lsb_first = b[0];
        return c;
    endfunction

    function automatic logic [7:0] ctl_to_byte(input ctl_t c);
        return {c.irq_en, c.enable, 1'b0, c.master, c.cpol, c.cpha, c.ss_drive, c.lsb_first};
    endfunction

    // position in the byte of the k-th bit on the wire
    function automatic logic [CNT_W-1:0] bit_slot(input logic lsb, input logic [CNT_W-1:0] k);
        return lsb ? k : (CNT_W'(FRAME_BITS - 1) - k);
    endfunction

endpackage

// File: rtl/spim_rate_gen.sv
module spim_rate_gen #(
    parameter int PRE_W = 3,
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    input  logic [EXP_W-1:0] expo,
    output logic             tick
);
    // longest half period: 2^PRE_W * 2^(2^EXP_W - 1)
    localparam int HALF_W = PRE_W + (1 << EXP_W);

    logic [HALF_W-1:0] half_len;
    logic [HALF_W-1:0] cnt_q;

    assign half_len = (HALF_W'(pre) + HALF_W'(1)) << expo;
    assign tick     = run && (cnt_q == half_len - HALF_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end

endmodule

// File: rtl/spim_shift_engine.sv
module spim_shift_engine
    import spim_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  abort,
    input  logic                  tick,
    input  logic                  cfg_cpol,
    input  logic                  cfg_cpha,
    input  logic                  cfg_lsb,
    input  logic [FRAME_BITS-1:0] tx_byte,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  busy,
    output logic                  run,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rx_byte
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    eng_state_t            state_q, state_d;
    logic [CNT_W-1:0]      bit_q;
    logic                  sclk_q;
    logic                  mosi_q;
    logic [FRAME_BITS-1:0] tx_q;
    logic [FRAME_BITS-1:0] rx_q;
    logic                  m_cpha;
    logic                  m_lsb;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:   if (start) state_d = ENG_LEAD;
            ENG_LEAD:   if (tick)  state_d = ENG_TRAIL;
            ENG_TRAIL:  if (tick)  state_d = (bit_q == LAST_BIT) ? ENG_FINISH : ENG_LEAD;
            ENG_FINISH: state_d = ENG_IDLE;
        endcase
        if (abort) state_d = ENG_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // datapath and serial outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
            tx_q   <= '0;
            rx_q   <= '0;
            m_cpha <= 1'b0;
            m_lsb  <= 1'b0;
        end else if (!abort) begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        tx_q   <= tx_byte;
                        m_cpha <= cfg_cpha;
                        m_lsb  <= cfg_lsb;
                        bit_q  <= '0;
                        sclk_q <= cfg_cpol;
                        mosi_q <= tx_byte[bit_slot(cfg_lsb, '0)];
                    end
                end
                ENG_LEAD: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        if (!m_cpha) rx_q[bit_slot(m_lsb, bit_q)] <= miso;
                        else         mosi_q <= tx_q[bit_slot(m_lsb, bit_q)];
                    end
                end
                ENG_TRAIL: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        bit_q  <= bit_q + CNT_W'(1);
                        if (m_cpha) begin
                            rx_q[bit_slot(m_lsb, bit_q)] <= miso;
                        end else if (bit_q != LAST_BIT) begin
                            mosi_q <= tx_q[bit_slot(m_lsb, bit_q + CNT_W'(1))];
                        end
                    end
                end
                ENG_FINISH: ;
            endcase
        end
    end

    assign run     = (state_q == ENG_LEAD) || (state_q == ENG_TRAIL);
    assign busy    = (state_q != ENG_IDLE);
    assign done    = (state_q == ENG_FINISH);
    assign sclk    = run ? sclk_q : cfg_cpol;
    assign mosi    = mosi_q;
    assign rx_byte = rx_q;

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ENG_IDLE));

    assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !abort) |=> $stable(mosi));

endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int SS_BIT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic                  eng_busy,
    input  logic                  eng_done,
    input  logic [FRAME_BITS-1:0] eng_rx,
    input  logic                  ss_in_n,
    output logic                  cfg_cpol,
    output logic                  cfg_cpha,
    output logic                  cfg_lsb,
    output logic [RATE_PRE_W-1:0] pre,
    output logic [RATE_EXP_W-1:0] expo,
    output logic                  eng_start,
    output logic                  eng_abort,
    output logic                  ss_n,
    output logic                  irq_done,
    output logic                  irq_fault
);
    ctl_t                  ctl_q;
    logic [7:0]            aux_q, port_q, dir_q;
    logic [RATE_PRE_W-1:0] pre_q;
    logic [RATE_EXP_W-1:0] expo_q;
    logic [2:0]            flags_q;   // {done, collision, fault}
    logic [2:0]            armed_q;

    logic hit_ctrl, hit_aux, hit_rate, hit_stat, hit_data, hit_port, hit_dir;
    logic wr_data, data_rd, stat_rd, fault_now, collide_now;
    logic [2:0] set_now, clr_now;
    logic [7:0] rate_rd, stat_rd_val;

    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_aux  = (bus_addr == ADDR_W'(OFS_AUX));
    assign hit_rate = (bus_addr == ADDR_W'(OFS_RATE));
    assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
    assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
    assign hit_port = (bus_addr == ADDR_W'(OFS_PORT));
    assign hit_dir  = (bus_addr == ADDR_W'(OFS_DIR));

    assign wr_data   = bus_wr && hit_data;
    assign data_rd   = bus_rd && hit_data;
    assign stat_rd   = bus_rd && hit_stat;
    assign fault_now = ctl_q.enable && ctl_q.master && !ctl_q.ss_drive && !ss_in_n;
    assign collide_now = wr_data && eng_busy;
    assign eng_start = wr_data && ctl_q.enable && ctl_q.master && !eng_busy && !fault_now;
    assign eng_abort = fault_now;

    assign set_now = {eng_done, collide_now, fault_now};
    assign clr_now = data_rd ? armed_q : 3'b000;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            aux_q  <= '0;
            port_q <= '0;
            dir_q  <= '0;
            pre_q  <= '0;
            expo_q <= '0;
        end else begin
            if (bus_wr && hit_ctrl) ctl_q <= ctl_from_byte(bus_wdata);
            if (fault_now)          ctl_q.master <= 1'b0;
            if (bus_wr && hit_aux)  aux_q <= bus_wdata;
            if (bus_wr && hit_port) port_q <= bus_wdata;
            if (bus_wr && hit_dir)  dir_q <= bus_wdata;
            if (bus_wr && hit_rate) begin
                pre_q  <= bus_wdata[RATE_PRE_LSB +: RATE_PRE_W];
                expo_q <= bus_wdata[0 +: RATE_EXP_W];
            end
        end
    end

    // two-step flag clearing: status read arms, data read clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            armed_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_now) | set_now;
            if (data_rd)      armed_q <= '0;
            else if (stat_rd) armed_q <= flags_q;
        end
    end

    always_comb begin
        rate_rd = '0;
        rate_rd[RATE_PRE_LSB +: RATE_PRE_W] = pre_q;
        rate_rd[0 +: RATE_EXP_W]            = expo_q;
        stat_rd_val = '0;
        stat_rd_val[STAT_DONE_BIT]  = flags_q[2];
        stat_rd_val[STAT_COLL_BIT]  = flags_q[1];
        stat_rd_val[STAT_FAULT_BIT] = flags_q[0];
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl)      bus_rdata = ctl_to_byte(ctl_q);
        else if (hit_aux)  bus_rdata = aux_q;
        else if (hit_rate) bus_rdata = rate_rd;
        else if (hit_stat) bus_rdata = stat_rd_val;
        else if (hit_data) bus_rdata = 8'(eng_rx);
        else if (hit_port) bus_rdata = port_q;
        else if (hit_dir)  bus_rdata = dir_q;
    end

    assign cfg_cpol  = ctl_q.cpol;
    assign cfg_cpha  = ctl_q.cpha;
    assign cfg_lsb   = ctl_q.lsb_first;
    assign pre       = pre_q;
    assign expo      = expo_q;
    assign ss_n      = dir_q[SS_BIT] ? port_q[SS_BIT] : 1'b1;
    assign irq_done  = ctl_q.irq_en && flags_q[2];
    assign irq_fault = ctl_q.irq_en && flags_q[0];

    assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> flags_q[2]);

    assert_collision_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && eng_busy) |=> flags_q[1]);

    assert_fault_drops_master_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_now |=> !ctl_q.master);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[2] && !data_rd) |=> flags_q[2]);

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spim_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n,
    input  logic              ss_in_n,
    output logic              irq_done,
    output logic              irq_fault
);
    logic                  cfg_cpol, cfg_cpha, cfg_lsb;
    logic [RATE_PRE_W-1:0] pre;
    logic [RATE_EXP_W-1:0] expo;
    logic                  eng_start, eng_abort, eng_busy, eng_run, eng_done, tick;
    logic [FRAME_BITS-1:0] eng_rx;

    spim_regs #(.ADDR_W(ADDR_W), .SS_BIT(3)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_rx(eng_rx),
        .ss_in_n(ss_in_n),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb(cfg_lsb),
        .pre(pre), .expo(expo),
        .eng_start(eng_start), .eng_abort(eng_abort),
        .ss_n(ss_n), .irq_done(irq_done), .irq_fault(irq_fault)
    );

    spim_rate_gen #(.PRE_W(RATE_PRE_W), .EXP_W(RATE_EXP_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(eng_run),
        .pre(pre), .expo(expo), .tick(tick)
    );

    spim_shift_engine u_engine (
        .clk(clk), .rst_n(rst_n),
        .start(eng_start), .abort(eng_abort), .tick(tick),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb(cfg_lsb),
        .tx_byte(bus_wdata[FRAME_BITS-1:0]), .miso(miso),
        .sclk(sclk), .mosi(mosi), .busy(eng_busy), .run(eng_run),
        .done(eng_done), .rx_byte(eng_rx)
    );

endmodule

// File: tb/spi_host_ctrl_bench.sv
module spi_host_ctrl_bench;
    import spim_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sclk, mosi, miso, ss_n, irq_done, irq_fault;
    logic       ss_in_n = 1'b1;

    always #10 clk = ~clk;   // 50 MHz

    spi_host_ctrl u_spi_host_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ss_n(ss_n), .ss_in_n(ss_in_n), .irq_done(irq_done), .irq_fault(irq_fault)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // ---------------- slave model / monitor ----------------
    logic [7:0] slv_tx = '0;
    logic [7:0] slv_rx = '0;
    logic       cfg_cpha = 1'b0, cfg_lsb = 1'b0;
    logic       last_sclk = 1'b0;
    int         ecnt = 0;
    logic [7:0] exp_q[$];

    function automatic int wire_pos(input int k, input logic lsb);
        return lsb ? k : 7 - k;
    endfunction

    function automatic int slave_pos(input int e, input logic cpha, input logic lsb);
        int k;
        if (cpha) k = (e == 0) ? 0 : (e - 1) / 2;
        else      k = e / 2;
        return wire_pos(k, lsb);
    endfunction

    assign miso = slv_tx[slave_pos(ecnt, cfg_cpha, cfg_lsb)];

    always @(sclk or ss_n) begin
        if (ss_n !== 1'b0) begin
            ecnt = 0;
            last_sclk = sclk;
        end else if (sclk !== last_sclk) begin
            last_sclk = sclk;
            if ((ecnt % 2 == 0) == !cfg_cpha)
                slv_rx[wire_pos(ecnt / 2, cfg_lsb)] = mosi;
            ecnt++;
            if (ecnt == 16) begin
                ecnt = 0;
                if (exp_q.size() == 0) begin
                    check("R2 slave saw unexpected byte", int'(slv_rx), -1);
                end else begin
                    check("R2 MOSI byte at slave", int'(slv_rx), int'(exp_q.pop_front()));
                end
            end
        end
    end

    // ---------------- bus driver ----------------
    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = 5'(a); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] mk_ctl(input logic ie, input logic en, input logic ms,
                                          input logic cpol, input logic cpha, input logic lsb);
        return {ie, en, 1'b0, ms, cpol, cpha, 1'b0, lsb};
    endfunction

    task automatic setup(input logic ie, input logic cpol, input logic cpha, input logic lsb,
                         input int p, input int e, input logic [7:0] slv);
        wr(OFS_PORT, 8'h08);
        wr(OFS_CTRL, mk_ctl(ie, 1'b1, 1'b1, cpol, cpha, lsb));
        wr(OFS_RATE, {1'b0, 3'(p), 1'b0, 3'(e)});
        cfg_cpha = cpha; cfg_lsb = lsb; slv_tx = slv;
        wr(OFS_PORT, 8'h00);
    endtask

    task automatic xfer(input logic ie, input logic cpol, input logic cpha, input logic lsb,
                        input int p, input int e, input logic [7:0] tx, input logic [7:0] slv);
        logic [7:0] d;
        int half;
        half = (p + 1) << e;
        setup(ie, cpol, cpha, lsb, p, e, slv);
        exp_q.push_back(tx);
        wr(OFS_DATA, tx);
        repeat (16 * half) @(negedge clk);
        if (ie) check("R3 done not yet at 16H", int'(irq_done), 0);
        @(negedge clk);
        if (ie) check("R3 done at 16H+1", int'(irq_done), 1);
        else    check("R6 irq gated off", int'(irq_done), 0);
        check("R4 sclk rests at polarity", int'(sclk), int'(cpol));
        rd(OFS_STAT, d);
        check("R6 status done bit", int'(d), 'h80);
        rd(OFS_DATA, d);
        check(lsb ? "R5 lsb-first received byte" : "R2 received byte", int'(d), int'(slv));
        rd(OFS_STAT, d);
        check("R8 flag cleared after status+data", int'(d), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL all: watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(OFS_CTRL, d); check("R1 ctrl reset", int'(d), 0);
        rd(OFS_RATE, d); check("R1 rate reset", int'(d), 0);
        rd(OFS_STAT, d); check("R1 status reset", int'(d), 0);
        rd(OFS_PORT, d); check("R1 port reset", int'(d), 0);
        rd(OFS_DIR,  d); check("R1 dir reset", int'(d), 0);
        check("R10 ss high after reset", int'(ss_n), 1);
        check("R6 irqs low after reset", int'({irq_done, irq_fault}), 0);

        // R1 readback
        wr(OFS_AUX, 8'h5A); rd(OFS_AUX, d); check("R1 aux readback", int'(d), 'h5A);
        wr(OFS_CTRL, 8'hFF); rd(OFS_CTRL, d); check("R1 ctrl bit5 reads 0", int'(d), 'hDF);
        wr(OFS_CTRL, 8'h00);
        wr(OFS_RATE, 8'hFF); rd(OFS_RATE, d); check("R3 rate bits 7,3 read 0", int'(d), 'h77);
        rd(5'h03, d); check("R1 unmapped reads 0", int'(d), 0);

        // R10 select pin
        wr(OFS_PORT, 8'h00); @(negedge clk); check("R10 dir clear keeps ss high", int'(ss_n), 1);
        wr(OFS_DIR, 8'h08);  @(negedge clk); check("R10 ss low from port", int'(ss_n), 0);
        wr(OFS_PORT, 8'h08); @(negedge clk); check("R10 ss high from port", int'(ss_n), 1);

        // R2..R6 transfers in all modes and rates
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 8'hA5, 8'h3C);
        xfer(1'b1, 1'b0, 1'b1, 1'b0, 2, 1, 8'h96, 8'h4B);
        xfer(1'b1, 1'b1, 1'b0, 1'b1, 1, 0, 8'h01, 8'h80);
        xfer(1'b1, 1'b1, 1'b1, 1'b1, 0, 2, 8'hC3, 8'h7E);
        xfer(1'b0, 1'b0, 1'b0, 1'b0, 0, 1, 8'h5C, 8'hE1);

        // R11 disabled: data write ignored
        wr(OFS_PORT, 8'h08);
        wr(OFS_CTRL, mk_ctl(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        wr(OFS_DATA, 8'hFF);
        repeat (40) begin
            @(negedge clk);
            if (sclk !== 1'b0) n = 1;
        end
        check("R11 sclk stays at rest", int'(sclk), 0);
        check("R11 no done irq", int'(irq_done), 0);
        rd(OFS_STAT, d); check("R11 status stays zero", int'(d), 0);
        rd(OFS_DATA, d); check("R11 received byte unchanged", int'(d), 'hE1);

        // R8 data read alone does not clear
        setup(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 8'h69);
        exp_q.push_back(8'h18);
        wr(OFS_DATA, 8'h18);
        n = 0;
        while (!irq_done && n < 200) begin @(negedge clk); n++; end
        rd(OFS_DATA, d); check("R2 received byte", int'(d), 'h69);
        @(negedge clk);
        check("R8 data read alone keeps flag", int'(irq_done), 1);
        rd(OFS_STAT, d);
        rd(OFS_DATA, d);
        @(negedge clk);
        check("R8 irq low after status+data", int'(irq_done), 0);

        // R7 write collision
        setup(1'b1, 1'b0, 1'b0, 1'b0, 0, 1, 8'h22);
        exp_q.push_back(8'h11);
        wr(OFS_DATA, 8'h11);
        repeat (3) @(negedge clk);
        wr(OFS_DATA, 8'h99);
        n = 0;
        while (!irq_done && n < 200) begin @(negedge clk); n++; end
        rd(OFS_STAT, d); check("R7 collision and done set", int'(d), 'hC0);
        rd(OFS_DATA, d); check("R7 received byte untouched", int'(d), 'h22);
        rd(OFS_STAT, d); check("R8 both flags cleared", int'(d), 0);

        // R9 mode fault mid-byte
        setup(1'b1, 1'b0, 1'b0, 1'b0, 0, 2, 8'h0F);
        wr(OFS_DATA, 8'hF0);
        repeat (10) @(negedge clk);
        ss_in_n = 1'b0;
        @(negedge clk);
        ss_in_n = 1'b1;
        @(negedge clk);
        check("R9 fault irq", int'(irq_fault), 1);
        check("R9 sclk back at rest", int'(sclk), 0);
        rd(OFS_CTRL, d); check("R9 master bit cleared", int'(d), 'hC0);
        repeat (100) @(negedge clk);
        check("R9 no done after abort", int'(irq_done), 0);
        rd(OFS_STAT, d); check("R9 fault status bit", int'(d), 'h10);
        rd(OFS_DATA, d);
        rd(OFS_STAT, d); check("R8 fault flag cleared", int'(d), 0);
        check("R6 fault irq low", int'(irq_fault), 0);
        wr(OFS_PORT, 8'h08);

        check("R2 scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule